// File: doc/BRIEF.md
# Fractional-Delay Cubic Sample Interpolator

This block resamples a fixed-rate complex baseband stream at instants chosen by an external timing controller. In-phase and quadrature samples arrive at the converter rate and are held in a four-deep sliding window. The window moves by one place whenever a new sample is flagged. When the controller raises its strobe, the block takes a snapshot of the window and the fractional interval `mu`, and returns one interpolated I/Q pair a fixed number of cycles later.

Each interpolant is the value of the cubic that passes through the four window samples, taken at a fractional distance `mu/256` past the second-oldest sample. The cubic is evaluated in Farrow form with Horner's rule over three pipelined multiply-add stages. It is computed exactly, then rounded once and saturated to the sample width. Because the strobe and `mu` come from the timing loop, the input and output rates need not be integer multiples. A locked loop usually strobes about twice per symbol, but the pipeline accepts a strobe on every cycle.

Top module: `fdinterp_top`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `outValid` is 0 and `outI` and `outQ` are 0.
- R2: The window is filled only on cycles with `sampleValid` high. On other cycles the values on `sampleI` and `sampleQ` have no effect on any later output.
- R3: A strobe uses the window as it stood before that cycle's edge. A sample presented with `sampleValid` in the same cycle as the strobe is not part of that interpolant, but it is part of later ones.
- R4: Name the window samples p(-1) (oldest), p(0), p(1) and p(2) (newest). Each output is floor(y + 1/2), where y is the cubic through (k, p(k)) evaluated at t = mu/256 and `mu` is an unsigned 8-bit value.
- R5: With `mu` = 0 the output equals p(0) exactly.
- R6: Results above 2047 are output as 2047, and results below -2048 are output as -2048 (12-bit two's complement).
- R7: Each strobe gives exactly one `outValid` pulse. The pulse is seen five rising edges after the edge that samples the strobe, and strobes on consecutive cycles give results on consecutive cycles, in order.
- R8: I and Q are computed independently from their own windows, using the same `mu` and strobe.
- R9: `outI` and `outQ` keep their last value on every cycle where `outValid` is low.
- R10: `outValid` is never raised without a matching earlier strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Marks a new input sample pair |
| sampleI | input | 12 | In-phase input sample, signed |
| sampleQ | input | 12 | Quadrature input sample, signed |
| strobe | input | 1 | Requests an interpolant from the current window |
| mu | input | 8 | Fractional interval, unsigned, weight mu/256 |
| outValid | output | 1 | One-cycle pulse marking a new interpolant |
| outI | output | 12 | In-phase interpolant, signed |
| outQ | output | 12 | Quadrature interpolant, signed |

## Verification
The window shift and the strobe snapshot can fall in the same cycle. The bench provokes this by raising `sampleValid` with distinct new data together with `strobe`. The expected value is built from the bench's own window copy taken before that sample is shifted in, so an implementation that lets the new sample leak into the snapshot gives a miscompare. Long random runs mix coincident, isolated and back-to-back strobes with stalled input cycles that carry garbage data, so the same collision is also exercised while the pipeline is full.

// File: rtl/fdinterp_pkg.sv
package fdinterp_pkg;

  // Fixed cubic Farrow structure: four taps, five register stages.
  localparam int TAPS       = 4;
  localparam int PIPE_DEPTH = 5;
  localparam int LANES      = 2;

  // Stage enables handed from control to each datapath lane.
  typedef struct packed {
    logic capture;   // snapshot window into Farrow coefficients
    logic hornerA;   // c3*mu + c2
    logic hornerB;   // (..)*mu + c1
    logic hornerC;   // (..)*mu + c0
    logic finish;    // round, divide by 6, saturate, load output
  } ctlStrobes_t;

endpackage

// File: rtl/fdinterp_ctrl.sv
module fdinterp_ctrl
  import fdinterp_pkg::*;
#(
  parameter int MU_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            strobe,
  input  logic [MU_W-1:0] mu,
  output ctlStrobes_t     ctl,
  output logic [MU_W-1:0] muPipe [3],
  output logic            outValid
);

  logic [PIPE_DEPTH-1:0] stageVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageVld[0] <= 1'b0;
    else       stageVld[0] <= strobe;
  end

  for (genvar s = 1; s < PIPE_DEPTH; s++) begin : gVld
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageVld[s] <= 1'b0;
      else       stageVld[s] <= stageVld[s-1];
    end
  end

  always_comb begin
    ctl.capture = strobe;
    ctl.hornerA = stageVld[0];
    ctl.hornerB = stageVld[1];
    ctl.hornerC = stageVld[2];
    ctl.finish  = stageVld[3];
  end

  // mu travels beside the data so each Horner step sees its own interpolant's mu.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muPipe[0] <= '0;
      muPipe[1] <= '0;
      muPipe[2] <= '0;
    end else begin
      if (ctl.capture) muPipe[0] <= mu;
      if (ctl.hornerA) muPipe[1] <= muPipe[0];
      if (ctl.hornerB) muPipe[2] <= muPipe[1];
    end
  end

  assign outValid = stageVld[PIPE_DEPTH-1];

endmodule

// File: rtl/fdinterp_lane.sv
module fdinterp_lane
  import fdinterp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int MU_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  ctlStrobes_t              ctl,
  input  logic [MU_W-1:0]          muA,
  input  logic [MU_W-1:0]          muB,
  input  logic [MU_W-1:0]          muC,
  output logic signed [DATA_W-1:0] sampleOut
);

  localparam int CW = DATA_W + 4;            // 6x-scaled coefficients
  localparam int AW = DATA_W + 3*MU_W + 8;   // exact Horner accumulator
  localparam int SH = 3*MU_W;                // mu^3 scale
  localparam int VW = AW - SH;
  localparam logic signed [VW-1:0] OUT_MAX = VW'((2**(DATA_W-1)) - 1);
  localparam logic signed [VW-1:0] OUT_MIN = VW'(-(2**(DATA_W-1)));

  // ---------------- sample window, index 0 newest ----------------
  logic signed [DATA_W-1:0] win [TAPS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++) win[k] <= '0;
    end else if (sampleValid) begin
      win[0] <= sampleIn;
      for (int k = 1; k < TAPS; k++) win[k] <= win[k-1];
    end
  end

  // ---------------- Farrow coefficients scaled by 6 ----------------
  function automatic logic signed [CW-1:0] times3(input logic signed [CW-1:0] x);
    return (x <<< 1) + x;
  endfunction

  logic signed [CW-1:0] pm1, p0, p1, p2;
  logic signed [CW-1:0] k0, k1, k2, k3;

  always_comb begin
    pm1 = CW'(win[3]);
    p0  = CW'(win[2]);
    p1  = CW'(win[1]);
    p2  = CW'(win[0]);
    k0  = times3(p0) <<< 1;
    k1  = (times3(p1) <<< 1) - (pm1 <<< 1) - times3(p0) - p2;
    k2  = times3(pm1) - (times3(p0) <<< 1) + times3(p1);
    k3  = p2 - pm1 + times3(p0) - times3(p1);
  end

  // ---------------- pipelined Horner evaluation ----------------
  logic signed [CW-1:0] c0R, c1R, c2R, c3R, c0B, c1B, c0C;
  logic signed [AW-1:0] accA, accB, accC;
  logic signed [MU_W:0] mAs, mBs, mCs;

  assign mAs = {1'b0, muA};
  assign mBs = {1'b0, muB};
  assign mCs = {1'b0, muC};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      c0R <= '0; c1R <= '0; c2R <= '0; c3R <= '0;
      c0B <= '0; c1B <= '0; c0C <= '0;
      accA <= '0; accB <= '0; accC <= '0;
    end else begin
      if (ctl.capture) begin
        c0R <= k0; c1R <= k1; c2R <= k2; c3R <= k3;
      end
      if (ctl.hornerA) begin
        accA <= AW'(c3R) * AW'(mAs) + (AW'(c2R) <<< MU_W);
        c1B  <= c1R;
        c0B  <= c0R;
      end
      if (ctl.hornerB) begin
        accB <= accA * AW'(mBs) + (AW'(c1B) <<< (2*MU_W));
        c0C  <= c0B;
      end
      if (ctl.hornerC) begin
        accC <= accB * AW'(mCs) + (AW'(c0C) <<< SH);
      end
    end
  end

  // ---------------- single rounding: floor((acc/2^SH + 3)/6) ----------------
  function automatic logic signed [DATA_W-1:0] roundSat(input logic signed [AW-1:0] acc);
    logic signed [AW-1:0] biased;
    logic signed [VW-1:0] v, mag, q;
    biased = acc + (AW'(3) <<< SH);
    v      = VW'(biased >>> SH);
    if (v < 0) begin
      mag = -v;
      q   = -((mag + VW'(5)) / VW'(6));
    end else begin
      q   = v / VW'(6);
    end
    if (q > OUT_MAX)      return OUT_MAX[DATA_W-1:0];
    else if (q < OUT_MIN) return OUT_MIN[DATA_W-1:0];
    else                  return q[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           sampleOut <= '0;
    else if (ctl.finish) sampleOut <= roundSat(accC);
  end

endmodule

// File: rtl/fdinterp_top.sv
module fdinterp_top
  import fdinterp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int MU_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleI,
  input  logic signed [DATA_W-1:0] sampleQ,
  input  logic                     strobe,
  input  logic [MU_W-1:0]          mu,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);

  ctlStrobes_t              ctl;
  logic [MU_W-1:0]          muPipe [3];
  logic signed [DATA_W-1:0] laneIn  [LANES];
  logic signed [DATA_W-1:0] laneOut [LANES];

  fdinterp_ctrl #(.MU_W(MU_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mu       (mu),
    .ctl      (ctl),
    .muPipe   (muPipe),
    .outValid (outValid)
  );

  assign laneIn[0] = sampleI;
  assign laneIn[1] = sampleQ;

  for (genvar ln = 0; ln < LANES; ln++) begin : gLane
    fdinterp_lane #(.DATA_W(DATA_W), .MU_W(MU_W)) uLane (
      .clk         (clk),
      .rstN        (rstN),
      .sampleValid (sampleValid),
      .sampleIn    (laneIn[ln]),
      .ctl         (ctl),
      .muA         (muPipe[0]),
      .muB         (muPipe[1]),
      .muC         (muPipe[2]),
      .sampleOut   (laneOut[ln])
    );
  end

  assign outI = laneOut[0];
  assign outQ = laneOut[1];

endmodule

// File: rtl/fdinterp_checker.sv
module fdinterp_checker
  import fdinterp_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     strobe,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outI,
  input logic signed [DATA_W-1:0] outQ,
  input ctlStrobes_t              ctl
);

  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R10: a result pulse always traces back to a strobe five edges earlier
  assert_valid_has_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe, 5));

  // R7: every strobe seen after reset produces its pulse
  assert_strobe_gives_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd5 && $past(strobe, 5)) |-> outValid);

  // R7: the final stage enable is followed by the visible pulse
  assert_finish_to_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> outValid);

  // R9: outputs hold while no result is flagged
  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outI) && $stable(outQ)));

endmodule

bind fdinterp_top fdinterp_checker #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .strobe   (strobe),
  .outValid (outValid),
  .outI     (outI),
  .outQ     (outQ),
  .ctl      (ctl)
);

// File: tb/tb_fdinterp_top.sv
module tb_fdinterp_top;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleValid = 1'b0;
  logic signed [11:0] sampleI = '0;
  logic signed [11:0] sampleQ = '0;
  logic              strobe = 1'b0;
  logic [7:0]        mu = '0;
  logic              outValid;
  logic signed [11:0] outI, outQ;

  fdinterp_top dut (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit running = 0, finished = 0;
  int wI[4], wQ[4];               // bench window, index 0 newest
  int qI[$], qQ[$], qCyc[$];
  string qTag[$];
  int lastI = 0, lastQ = 0;

  // Exact cubic through (-1,a),(0,b),(1,c),(2,d) at m/256, then floor(y+1/2), saturated.
  function automatic int expect_val(int a, int b, int c, int d, int m);
    longint la = a, lb = b, lc = c, ld = d, lm = m;
    longint p, den, q;
    p = (-la + 3*lb - 3*lc + ld) * lm*lm*lm
      + (3*la - 6*lb + 3*lc) * lm*lm * 256
      + (-2*la - 3*lb + 6*lc - ld) * lm * 65536
      + 6*lb * 64'sd16777216;
    p = p + 3 * 64'sd16777216;
    den = 6 * 64'sd16777216;
    q = p / den;
    if ((p % den) != 0 && p < 0) q = q - 1;
    if (q > 2047)  q = 2047;
    if (q < -2048) q = -2048;
    return int'(q);
  endfunction

  task automatic step(bit sv, int si, int sq, bit st, int m, string tag);
    @(negedge clk);
    sampleValid = sv; sampleI = 12'(si); sampleQ = 12'(sq);
    strobe = st; mu = 8'(m);
    if (st) begin
      // snapshot taken before this cycle's sample enters (R3)
      qI.push_back(expect_val(wI[3], wI[2], wI[1], wI[0], m));
      qQ.push_back(expect_val(wQ[3], wQ[2], wQ[1], wQ[0], m));
      qCyc.push_back(cyc);
      qTag.push_back(tag);
    end
    if (sv) begin
      for (int k = 3; k > 0; k--) begin wI[k] = wI[k-1]; wQ[k] = wQ[k-1]; end
      wI[0] = int'(12'sh0 + $signed(12'(si)));
      wQ[0] = int'(12'sh0 + $signed(12'(sq)));
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (running) begin
      if (outValid) begin
        checks++;
        if (qI.size() == 0) begin
          fails++;
          $display("FAIL R10: outValid=1 with nothing pending, expected 0");
        end else begin
          int ei, eq, ec;
          string tg;
          ei = qI.pop_front(); eq = qQ.pop_front(); ec = qCyc.pop_front(); tg = qTag.pop_front();
          if (int'(outI) != ei || int'(outQ) != eq || cyc != ec + 5) begin
            fails++;
            $display("FAIL %s: I=%0d Q=%0d cyc=%0d, expected I=%0d Q=%0d cyc=%0d",
                     tg, outI, outQ, cyc, ei, eq, ec + 5);
          end
        end
        lastI = int'(outI); lastQ = int'(outQ);
      end else begin
        checks++;
        if (int'(outI) != lastI || int'(outQ) != lastQ) begin
          fails++;
          $display("FAIL R9: I=%0d Q=%0d while idle, expected I=%0d Q=%0d",
                   outI, outQ, lastI, lastQ);
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R7: watchdog expired, pending=%0d expected 0", qI.size());
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin wI[k] = 0; wQ[k] = 0; end
    repeat (4) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outI !== 12'sd0 || outQ !== 12'sd0) begin
      fails++;
      $display("FAIL R1: in reset valid=%0b I=%0d Q=%0d, expected 0 0 0", outValid, outI, outQ);
    end
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outI !== 12'sd0 || outQ !== 12'sd0) begin
      fails++;
      $display("FAIL R1: after reset valid=%0b I=%0d Q=%0d, expected 0 0 0", outValid, outI, outQ);
    end
    running = 1;

    // fill with a curved ramp (R4, R8: Q differs from I)
    for (int k = 1; k <= 6; k++) step(1, 37*k*k - 300, -90*k + 55, 0, 0, "R4");
    // mu sweep on a fixed window; mu=0 must return p(0)
    step(0, 0, 0, 1, 0,   "R5");
    step(0, 0, 0, 1, 64,  "R4");
    step(0, 0, 0, 1, 128, "R4");
    step(0, 0, 0, 1, 255, "R4");
    step(0, 0, 0, 0, 0,   "R4");
    // sample and strobe in the same cycle
    step(1, 1500, -1700, 1, 200, "R3");
    step(1, -1200, 900, 1, 0,    "R3");
    step(1, 333, 444, 1, 77,     "R3");
    // stall cycles carrying garbage, then strobes
    for (int k = 0; k < 3; k++) step(0, $urandom_range(0, 4095), $urandom_range(0, 4095), 0, 0, "R2");
    step(0, 2047, -2048, 1, 100, "R2");
    step(0, -2048, 2047, 1, 0,   "R2");
    // saturation, I to +max, Q to -max
    step(1, -2048, 2047, 0, 0, "R6");
    step(1, 2047, -2048, 0, 0, "R6");
    step(1, 2047, -2048, 0, 0, "R6");
    step(1, -2048, 2047, 0, 0, "R6");
    step(0, 0, 0, 1, 128, "R6");
    step(0, 0, 0, 1, 200, "R6");
    // back-to-back strobes with random sample flow
    for (int k = 0; k < 40; k++)
      step($urandom_range(0, 1), $urandom_range(0, 4095), $urandom_range(0, 4095),
           1, $urandom_range(0, 255), "R7");
    // mixed traffic at roughly two strobes per symbol
    for (int k = 0; k < 400; k++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 4095), $urandom_range(0, 4095),
           $urandom_range(0, 1), $urandom_range(0, 255), "R8");
    for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 0, "R7");
    checks++;
    if (qI.size() != 0) begin
      fails++;
      $display("FAIL R7: %0d results missing, expected 0", qI.size());
    end
    finished = 1;
    summary();
    $finish;
  end

endmodule